// File: doc/BRIEF.md
# Filtered External Interrupt Edge Detector

This block turns sixteen external interrupt request pins, one non-maskable interrupt pin and an internal watchdog event into latched event flags. Each external request pin is brought into the clock domain by a two-stage synchronizer. It then passes through a glitch filter whose hold time, counted in system clocks, is set by software. Rising and falling transitions of the filtered level are detected separately. Each raises a flag only when its own enable bit is set.

The non-maskable pin is synchronized but not filtered. The watchdog event is already synchronous, so only its falling edge is detected. The two non-maskable enables can be written once only, and only a reset clears them. This keeps a running program from switching off non-maskable events.

Software sees four 32-bit registers on a single-cycle bus: the flag register, the rising-edge enables, the falling-edge enables and the filter length. The block drives one combined interrupt line and one non-maskable line.

Top module: `xirq_edge_unit`

## Requirements
- R1: After reset all four registers read 0, and both irq_out and nmi_out are low.
- R2: Bit i of the falling-enable register (offset 0x2C, bits 15:0) makes a falling transition of the filtered irq_pin[i] set flag bit i of the flag register (offset 0x24).
- R3: Bit i of the rising-enable register (offset 0x28, bits 15:0) makes a rising transition of the filtered irq_pin[i] set flag bit i. When both enables are set, either transition sets the flag.
- R4: Bit 31 of offset 0x2C enables falling edges of nmi_pin, which set flag bit 31. The first write to offset 0x2C fixes this bit. Later writes leave it unchanged, and only a reset clears it.
- R5: Bit 30 of offset 0x2C enables falling edges of wdog_evt, which set flag bit 30. It follows the same write-once and reset-only clear rule as bit 31.
- R6: A transition whose enable bit is 0 leaves the flag register unchanged.
- R7: Bits 3:0 of offset 0x30 hold the filter length L. The filtered level takes a new value only after the synchronized pin has held that value for L clocks, so a shorter pulse produces no edge. With L = 0 the filtered level follows the synchronized pin.
- R8: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. An edge that arrives in the same cycle as the clear keeps the flag set.
- R9: irq_out is high whenever any flag bit is set. nmi_out is high whenever flag bit 31 or flag bit 30 is set.
- R10: Unimplemented register bits, and addresses outside the four registers, read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_pin | input | 16 | External interrupt request pins, asynchronous |
| nmi_pin | input | 1 | External non-maskable interrupt pin, asynchronous |
| wdog_evt | input | 1 | Internal watchdog event level, synchronous |
| bus_sel | input | 1 | Bus access strobe |
| bus_we | input | 1 | Write when high, read when low |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the cycle of the access |
| irq_out | output | 1 | Combined interrupt request |
| nmi_out | output | 1 | Combined non-maskable request |

## Verification
The checker watches every cycle for four things. A set flag must stay set until a clear is written. A flag may rise only when an enabled edge is present, which also covers set-before-clear priority. A filtered level may change only towards the value the synchronizer held one cycle earlier. The non-maskable enables must never drop outside reset. The bench's scenarios are needed for the rest: the exact filter hold time against short glitches, the write-once lock seen through register reads, and the register map with its unimplemented bits.

// File: rtl/xirq_pkg.sv
package xirq_pkg;
  localparam int unsigned REG_W       = 32;
  localparam logic [7:0]  OFS_STAT    = 8'h24;
  localparam logic [7:0]  OFS_RISE    = 8'h28;
  localparam logic [7:0]  OFS_FALL    = 8'h2C;
  localparam logic [7:0]  OFS_FLEN    = 8'h30;
  localparam int unsigned BIT_NMI_PIN = 31;
  localparam int unsigned BIT_NMI_WD  = 30;

  // Write-one-to-clear update in which a new event beats the clear.
  function automatic logic [REG_W-1:0] w1c_update(input logic [REG_W-1:0] cur,
                                                  input logic [REG_W-1:0] clr,
                                                  input logic [REG_W-1:0] set);
    return (cur & ~clr) | set;
  endfunction
endpackage

// File: rtl/xirq_sync.sv
module xirq_sync #(
  parameter int unsigned W = 1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage1 <= '0;
      q      <= '0;
    end else begin
      stage1 <= d;
      q      <= stage1;
    end
  end
endmodule

// File: rtl/xirq_glitch_filter.sv
module xirq_glitch_filter #(
  parameter int unsigned LEN_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             din,
  input  logic [LEN_W-1:0] len,
  output logic             level,
  output logic             rise,
  output logic             fall
);
  logic [LEN_W-1:0] cnt;
  logic             differ;
  logic             commit;

  // True when the input has held its new value long enough to be accepted.
  function automatic logic held_enough(input logic [LEN_W-1:0] c,
                                       input logic [LEN_W-1:0] l);
    return (l == '0) || (c >= LEN_W'(l - 1'b1));
  endfunction

  assign differ = din ^ level;
  assign commit = differ && held_enough(cnt, len);
  assign rise   = commit & din;
  assign fall   = commit & ~din;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level <= 1'b0;
      cnt   <= '0;
    end else if (commit) begin
      level <= din;
      cnt   <= '0;
    end else if (differ) begin
      cnt   <= cnt + 1'b1;
    end else begin
      cnt   <= '0;
    end
  end
endmodule

// File: rtl/xirq_regs.sv
module xirq_regs
  import xirq_pkg::*;
#(
  parameter int unsigned N_IRQ  = 16,
  parameter int unsigned FLT_W  = 4,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  input  logic [REG_W-1:0]  set_vec,
  output logic [REG_W-1:0]  clr_vec,
  output logic [REG_W-1:0]  flags,
  output logic [N_IRQ-1:0]  rise_en,
  output logic [N_IRQ-1:0]  fall_en,
  output logic              nmi_pin_en,
  output logic              nmi_wd_en,
  output logic [FLT_W-1:0]  flt_len
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_RISE = ADDR_W'(OFS_RISE);
  localparam logic [ADDR_W-1:0] A_FALL = ADDR_W'(OFS_FALL);
  localparam logic [ADDR_W-1:0] A_FLEN = ADDR_W'(OFS_FLEN);

  logic wr;
  logic once_done;

  assign wr      = bus_sel & bus_we;
  assign clr_vec = (wr && bus_addr == A_STAT) ? bus_wdata : '0;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags      <= '0;
      rise_en    <= '0;
      fall_en    <= '0;
      nmi_pin_en <= 1'b0;
      nmi_wd_en  <= 1'b0;
      once_done  <= 1'b0;
      flt_len    <= '0;
    end else begin
      flags <= w1c_update(flags, clr_vec, set_vec);
      if (wr && bus_addr == A_RISE) rise_en <= bus_wdata[N_IRQ-1:0];
      if (wr && bus_addr == A_FLEN) flt_len <= bus_wdata[FLT_W-1:0];
      if (wr && bus_addr == A_FALL) begin
        fall_en   <= bus_wdata[N_IRQ-1:0];
        once_done <= 1'b1;
        if (!once_done) begin
          nmi_pin_en <= bus_wdata[BIT_NMI_PIN];
          nmi_wd_en  <= bus_wdata[BIT_NMI_WD];
        end
      end
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      case (bus_addr)
        A_STAT: bus_rdata = flags;
        A_RISE: bus_rdata[N_IRQ-1:0] = rise_en;
        A_FALL: begin
          bus_rdata[N_IRQ-1:0]   = fall_en;
          bus_rdata[BIT_NMI_PIN] = nmi_pin_en;
          bus_rdata[BIT_NMI_WD]  = nmi_wd_en;
        end
        A_FLEN: bus_rdata[FLT_W-1:0] = flt_len;
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/xirq_edge_unit.sv
module xirq_edge_unit
  import xirq_pkg::*;
#(
  parameter int unsigned N_IRQ  = 16,
  parameter int unsigned FLT_W  = 4,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_IRQ-1:0]  irq_pin,
  input  logic              nmi_pin,
  input  logic              wdog_evt,
  input  logic              bus_sel,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [REG_W-1:0]  bus_wdata,
  output logic [REG_W-1:0]  bus_rdata,
  output logic              irq_out,
  output logic              nmi_out
);
  localparam int unsigned SYNC_W = N_IRQ + 1;

  logic [SYNC_W-1:0] pin_sync;
  logic [N_IRQ-1:0]  irq_sync;
  logic [N_IRQ-1:0]  irq_lvl;
  logic [N_IRQ-1:0]  irq_rise;
  logic [N_IRQ-1:0]  irq_fall;
  logic              nmi_sync;
  logic              nmi_prev;
  logic              nmi_fall;
  logic              wd_prev;
  logic              wd_fall;
  logic [REG_W-1:0]  set_vec;
  logic [REG_W-1:0]  clr_vec;
  logic [REG_W-1:0]  flags;
  logic [N_IRQ-1:0]  rise_en;
  logic [N_IRQ-1:0]  fall_en;
  logic              nmi_pin_en;
  logic              nmi_wd_en;
  logic [FLT_W-1:0]  flt_len;

  xirq_sync #(.W(SYNC_W)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     ({nmi_pin, irq_pin}),
    .q     (pin_sync)
  );

  assign irq_sync = pin_sync[N_IRQ-1:0];
  assign nmi_sync = pin_sync[N_IRQ];

  for (genvar i = 0; i < N_IRQ; i++) begin : g_flt
    xirq_glitch_filter #(.LEN_W(FLT_W)) u_flt (
      .clk   (clk),
      .rst_n (rst_n),
      .din   (irq_sync[i]),
      .len   (flt_len),
      .level (irq_lvl[i]),
      .rise  (irq_rise[i]),
      .fall  (irq_fall[i])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nmi_prev <= 1'b0;
      wd_prev  <= 1'b0;
    end else begin
      nmi_prev <= nmi_sync;
      wd_prev  <= wdog_evt;
    end
  end

  assign nmi_fall = nmi_prev & ~nmi_sync;
  assign wd_fall  = wd_prev & ~wdog_evt;

  always_comb begin
    set_vec              = '0;
    set_vec[N_IRQ-1:0]   = (irq_rise & rise_en) | (irq_fall & fall_en);
    set_vec[BIT_NMI_PIN] = nmi_fall & nmi_pin_en;
    set_vec[BIT_NMI_WD]  = wd_fall & nmi_wd_en;
  end

  xirq_regs #(.N_IRQ(N_IRQ), .FLT_W(FLT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .bus_sel    (bus_sel),
    .bus_we     (bus_we),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .set_vec    (set_vec),
    .clr_vec    (clr_vec),
    .flags      (flags),
    .rise_en    (rise_en),
    .fall_en    (fall_en),
    .nmi_pin_en (nmi_pin_en),
    .nmi_wd_en  (nmi_wd_en),
    .flt_len    (flt_len)
  );

  assign irq_out = |flags;
  assign nmi_out = flags[BIT_NMI_PIN] | flags[BIT_NMI_WD];
endmodule

// File: rtl/xirq_edge_unit_chk.sv
module xirq_edge_unit_chk #(
  parameter int unsigned N_IRQ = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [31:0]      flags,
  input logic [31:0]      set_vec,
  input logic [31:0]      clr_vec,
  input logic [N_IRQ-1:0] irq_lvl,
  input logic [N_IRQ-1:0] irq_sync,
  input logic             nmi_pin_en,
  input logic             nmi_wd_en,
  input logic             irq_out
);
  // R8: a flag that was set and not cleared is still set one cycle later
  a_r8_flag_holds: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & $past(flags & ~clr_vec)) == $past(flags & ~clr_vec)));

  // R6: a flag may only come up where an enabled edge was present
  a_r6_no_unprompted_set: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((flags & ~$past(flags) & ~$past(set_vec)) == '0));

  // R8: an edge wins over a simultaneous clear
  a_r8_set_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(set_vec) & ~flags) == '0));

  // R7: the filtered level only moves towards the earlier synchronized value
  a_r7_filter_follows_sync: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (((irq_lvl ^ $past(irq_lvl)) & (irq_lvl ^ $past(irq_sync))) == '0));

  // R4: the pin enable never drops outside reset
  a_r4_nmi_en_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_pin_en |=> nmi_pin_en);

  // R5: the watchdog enable never drops outside reset
  a_r5_wd_en_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    nmi_wd_en |=> nmi_wd_en);

  // R9: the combined line comes up only together with a new event
  a_r9_irq_out_cause: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_out) |-> ($past(set_vec) != '0));
endmodule

bind xirq_edge_unit xirq_edge_unit_chk #(.N_IRQ(N_IRQ)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .flags      (flags),
  .set_vec    (set_vec),
  .clr_vec    (clr_vec),
  .irq_lvl    (irq_lvl),
  .irq_sync   (irq_sync),
  .nmi_pin_en (nmi_pin_en),
  .nmi_wd_en  (nmi_wd_en),
  .irq_out    (irq_out)
);

// File: tb/xirq_edge_unit_test.sv
module xirq_edge_unit_test;
  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] STAT = 8'h24, RISE = 8'h28, FALL = 8'h2C, FLEN = 8'h30;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] irq_pin = 16'hFFFF;
  logic        nmi_pin = 1'b1;
  logic        wdog_evt = 1'b0;
  logic        bus_sel = 1'b0;
  logic        bus_we = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [31:0] bus_wdata = 32'h0;
  logic [31:0] bus_rdata;
  logic        irq_out;
  logic        nmi_out;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;

  xirq_edge_unit uut (
    .clk(clk), .rst_n(rst_n), .irq_pin(irq_pin), .nmi_pin(nmi_pin),
    .wdog_evt(wdog_evt), .bus_sel(bus_sel), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .irq_out(irq_out), .nmi_out(nmi_out)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_write(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_we = 1'b0; bus_wdata = 32'h0;
  endtask

  task automatic bus_read(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 1'b0;
  endtask

  task automatic expect_reg(input string req, input logic [7:0] a, input logic [31:0] exp);
    logic [31:0] v;
    bus_read(a, v);
    check(req, v, exp);
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(4);
  endtask

  task automatic t_reset_state();
    expect_reg("R1 status", STAT, 32'h0);
    expect_reg("R1 rise_en", RISE, 32'h0);
    expect_reg("R1 fall_en", FALL, 32'h0);
    expect_reg("R1 filter", FLEN, 32'h0);
    check("R1 irq_out", {31'h0, irq_out}, 32'h0);
    check("R1 nmi_out", {31'h0, nmi_out}, 32'h0);
  endtask

  task automatic t_falling();
    bus_write(FALL, 32'hC000_0008);
    expect_reg("R2 fall_en readback", FALL, 32'hC000_0008);
    irq_pin[3] = 1'b0;
    wait_cyc(6);
    expect_reg("R2 falling edge on line 3", STAT, 32'h0000_0008);
    check("R9 irq_out with flag", {31'h0, irq_out}, 32'h1);
    check("R9 nmi_out without nmi flag", {31'h0, nmi_out}, 32'h0);
    irq_pin[5] = 1'b0;
    wait_cyc(6);
    expect_reg("R6 disabled falling edge on line 5", STAT, 32'h0000_0008);
    irq_pin[3] = 1'b1;
    irq_pin[5] = 1'b1;
    wait_cyc(6);
    expect_reg("R6 disabled rising edges", STAT, 32'h0000_0008);
  endtask

  task automatic t_clear();
    bus_write(STAT, 32'h0000_0001);
    expect_reg("R8 write 1 to clear bit", STAT, 32'h0000_0008);
    bus_write(STAT, 32'h0000_0008);
    expect_reg("R8 cleared", STAT, 32'h0);
    check("R9 irq_out after clear", {31'h0, irq_out}, 32'h0);
  endtask

  task automatic t_rising();
    bus_write(RISE, 32'h0000_0009);
    irq_pin[0] = 1'b0;
    wait_cyc(6);
    expect_reg("R3 falling on rise-only line", STAT, 32'h0);
    irq_pin[0] = 1'b1;
    wait_cyc(6);
    expect_reg("R3 rising edge line 0", STAT, 32'h0000_0001);
    bus_write(STAT, 32'hFFFF_FFFF);
    irq_pin[3] = 1'b0;
    wait_cyc(6);
    expect_reg("R3 both enables, falling", STAT, 32'h0000_0008);
    bus_write(STAT, 32'h0000_0008);
    irq_pin[3] = 1'b1;
    wait_cyc(6);
    expect_reg("R3 both enables, rising", STAT, 32'h0000_0008);
    bus_write(STAT, 32'hFFFF_FFFF);
    bus_write(RISE, 32'h0);
  endtask

  task automatic t_nmi_once();
    bus_write(FALL, 32'h0000_0008);
    expect_reg("R4 R5 later write ignored", FALL, 32'hC000_0008);
    nmi_pin = 1'b0;
    wait_cyc(6);
    expect_reg("R4 nmi falling edge", STAT, 32'h8000_0000);
    check("R9 nmi_out on pin flag", {31'h0, nmi_out}, 32'h1);
    check("R9 irq_out on pin flag", {31'h0, irq_out}, 32'h1);
    bus_write(STAT, 32'h8000_0000);
    check("R9 nmi_out cleared", {31'h0, nmi_out}, 32'h0);
    nmi_pin = 1'b1;
    wdog_evt = 1'b1;
    wait_cyc(3);
    expect_reg("R5 watchdog rise not flagged", STAT, 32'h0);
    wdog_evt = 1'b0;
    wait_cyc(3);
    expect_reg("R5 watchdog falling edge", STAT, 32'h4000_0000);
    check("R9 nmi_out on watchdog flag", {31'h0, nmi_out}, 32'h1);
    bus_write(STAT, 32'h4000_0000);
  endtask

  task automatic t_filter();
    bus_write(FLEN, 32'hFFFF_FFF5);
    expect_reg("R10 filter field only", FLEN, 32'h0000_0005);
    irq_pin[3] = 1'b0;
    wait_cyc(3);
    irq_pin[3] = 1'b1;
    wait_cyc(12);
    expect_reg("R7 short glitch rejected", STAT, 32'h0);
    @(negedge clk);
    irq_pin[3] = 1'b0;
    wait_cyc(4);
    check("R7 still filtering", {31'h0, irq_out}, 32'h0);
    wait_cyc(5);
    expect_reg("R7 held pulse accepted", STAT, 32'h0000_0008);
    irq_pin[3] = 1'b1;
    wait_cyc(10);
    bus_write(STAT, 32'hFFFF_FFFF);
    bus_write(FLEN, 32'h0);
  endtask

  task automatic t_unimpl();
    bus_write(RISE, 32'hFFFF_FFFF);
    expect_reg("R10 rise upper bits", RISE, 32'h0000_FFFF);
    bus_write(RISE, 32'h0);
    expect_reg("R10 unmapped low address", 8'h00, 32'h0);
    expect_reg("R10 unmapped address 0x34", 8'h34, 32'h0);
  endtask

  task automatic t_reset_clears_once();
    do_reset();
    expect_reg("R4 reset clears nmi enables", FALL, 32'h0);
    bus_write(FALL, 32'h0);
    bus_write(FALL, 32'hC000_0000);
    expect_reg("R4 R5 locked at zero", FALL, 32'h0);
    nmi_pin = 1'b0;
    wait_cyc(6);
    expect_reg("R6 nmi edge disabled", STAT, 32'h0);
    check("R6 nmi_out stays low", {31'h0, nmi_out}, 32'h0);
    nmi_pin = 1'b1;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    wait_cyc(3);
    rst_n = 1'b1;
    wait_cyc(4);
    t_reset_state();
    t_falling();
    t_clear();
    t_rising();
    t_nmi_once();
    t_filter();
    t_unimpl();
    t_reset_clears_once();
    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule